// File: doc/BRIEF.md
# SDRAM Burst Buffer and Width Converter

This block joins a wide AXI4-style burst port to a memory data path that is always 16 bits wide. On the write side it takes the address phase, gathers every data beat of the burst in a local buffer, and only then plays the burst out toward the memory as halfwords, one per cycle with no gaps. Each bus beat is split into `BUS_W/16` halfwords, least significant halfword first. Once the final halfword has gone out, it returns a single OKAY write response.

On the read side, an accepted read address becomes a one-cycle request toward the memory, together with the halfword count. The memory then pushes that many halfwords and cannot be stalled. The block packs them back into bus beats in the same halfword order. When the whole burst is held locally, it returns the beats on the R channel with RLAST on the final one and honours back-pressure. The two directions have separate buffers and state, so a write and a read may be in flight at the same time. Burst length varies per transaction, from 1 to `2**LEN_W` beats.

Command sequencing, addressing, refresh and memory timing belong to the neighbouring memory controller. An unsupported bus width (anything other than 16, 32 or 64) or an undersized buffer stops elaboration.

Top module: `sdram_burst_buffer`

## Requirements
- R1: After reset, aw_ready and ar_ready are 1, and w_ready, b_valid, r_valid, r_last, mw_valid, mw_start and mr_start are 0.
- R2: aw_ready is low while a write is in flight. w_ready is high only from the cycle after the address is accepted until aw_len+1 beats have been taken.
- R3: mw_start and mw_valid stay low until every beat of the burst has been accepted. mw_start is high in exactly the cycle of the first halfword, with mw_count = (aw_len+1)*BUS_W/16.
- R4: Halfwords leave on mw_data in beat order, and within each beat from bits [15:0] upward.
- R5: Once the first halfword appears, mw_valid stays high for exactly mw_count consecutive cycles.
- R6: b_valid with b_resp = 2'b00 (OKAY) rises in the cycle after the last halfword and holds until b_ready. aw_ready returns in the cycle after the response is taken.
- R7: In the cycle after a read address is accepted, mr_start is high for one cycle with mr_count = (ar_len+1)*BUS_W/16. ar_ready stays low until the last R beat is taken. The buffer holds a burst of the maximum length.
- R8: r_valid stays low until all mr_count halfwords have arrived. Each R beat carries its halfwords in arrival order from bits [15:0] upward.
- R9: r_last is high on exactly the final beat. While r_valid is high and r_ready is low, r_data and r_last hold.
- R10: mr_valid pulses while no read fill is in progress have no effect on any later read data.
- R11: A write burst and a read burst proceed concurrently and each completes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_len | input | LEN_W | Write burst length minus one |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | BUS_W | Write data beat |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | output | 2 | Write response code, always OKAY |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_len | input | LEN_W | Read burst length minus one |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_data | output | BUS_W | Read data beat |
| r_last | output | 1 | Final beat of the read burst |
| mw_start | output | 1 | First halfword of a memory write burst |
| mw_valid | output | 1 | Memory write halfword valid |
| mw_data | output | 16 | Memory write halfword |
| mw_count | output | LEN_W+log2(BUS_W/16)+1 | Halfwords in the memory write burst |
| mr_start | output | 1 | One-cycle memory read request |
| mr_count | output | LEN_W+log2(BUS_W/16)+1 | Halfwords requested from memory |
| mr_valid | input | 1 | Memory read halfword valid |
| mr_data | input | 16 | Memory read halfword |

## Verification
Several properties are checked on every cycle. The memory write burst never starts before all beats are held. Once started, it never breaks until mw_count halfwords have left. The write response follows the final halfword and holds. mr_start lasts one cycle, the read fill never exceeds the buffer, R beats wait for the full fill, and R beats hold under back-pressure. The halfword order in both directions, the exact counts, the ignoring of stray mr_valid pulses and concurrent traffic can only be shown by the bench scenarios. These compare every output against a behavioural queue model across bursts of 1, 4, 8, 16 and 256 beats, with stalled and unstalled handshakes.

// File: rtl/sdbuf_pkg.sv
package sdbuf_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_FILL,
    WS_PREP,
    WS_DRAIN,
    WS_LAST,
    WS_RESP
  } wr_state_e;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ISSUE,
    RS_FILL,
    RS_PREP,
    RS_SEND
  } rd_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/sdbuf_ram.sv
// Simple dual-port buffer: one write port, one registered read port.
module sdbuf_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sdbuf_wr.sv
// Write direction: collect a whole burst, then stream halfwords out.
module sdbuf_wr
  import sdbuf_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int LEN_W    = 8,
  parameter int DEPTH_HW = 512,
  parameter int CNT_W    = LEN_W + $clog2(BUS_W / 16) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aw_valid,
  output logic             aw_ready,
  input  logic [LEN_W-1:0] aw_len,
  input  logic             w_valid,
  output logic             w_ready,
  input  logic [BUS_W-1:0] w_data,
  output logic             b_valid,
  input  logic             b_ready,
  output logic [1:0]       b_resp,
  output logic             mw_start,
  output logic             mw_valid,
  output logic [15:0]      mw_data,
  output logic [CNT_W-1:0] mw_count
);

  localparam int RATIO   = BUS_W / 16;
  localparam int LANE_W  = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int DEPTH_B = DEPTH_HW / RATIO;
  localparam int ADDR_W  = $clog2(DEPTH_B);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(RATIO - 1);

  wr_state_e         state;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  wbeat;
  logic [LEN_W-1:0]  dbeat;
  logic [LANE_W-1:0] lane;
  logic [ADDR_W-1:0] raddr;
  logic [BUS_W-1:0]  q;
  logic              mem_we;

  assign aw_ready = (state == WS_IDLE);
  assign w_ready  = (state == WS_FILL);
  assign b_valid  = (state == WS_RESP);
  assign b_resp   = RESP_OKAY;
  assign mem_we   = (state == WS_FILL) && w_valid;

  // Address look-ahead so the registered read port has the beat ready.
  always_comb begin
    if (state == WS_DRAIN && lane == LANE_LAST) raddr = ADDR_W'(dbeat) + ADDR_W'(1);
    else if (state == WS_DRAIN)                 raddr = ADDR_W'(dbeat);
    else                                        raddr = '0;
  end

  sdbuf_ram #(.WIDTH(BUS_W), .DEPTH(DEPTH_B)) u_buf (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ADDR_W'(wbeat)),
    .wdata (w_data),
    .raddr (raddr),
    .rdata (q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WS_IDLE;
      len_q    <= '0;
      wbeat    <= '0;
      dbeat    <= '0;
      lane     <= '0;
      mw_start <= 1'b0;
      mw_valid <= 1'b0;
      mw_data  <= '0;
      mw_count <= '0;
    end else begin
      mw_start <= 1'b0;
      mw_valid <= 1'b0;
      case (state)
        WS_IDLE: if (aw_valid) begin
          len_q    <= aw_len;
          mw_count <= (CNT_W'(aw_len) + CNT_W'(1)) * CNT_W'(RATIO);
          wbeat    <= '0;
          state    <= WS_FILL;
        end
        WS_FILL: if (w_valid) begin
          wbeat <= wbeat + 1'b1;
          if (wbeat == len_q) state <= WS_PREP;
        end
        WS_PREP: begin
          dbeat <= '0;
          lane  <= '0;
          state <= WS_DRAIN;
        end
        WS_DRAIN: begin
          mw_valid <= 1'b1;
          mw_start <= (dbeat == '0) && (lane == '0);
          mw_data  <= q[16*lane +: 16];
          if (lane == LANE_LAST) begin
            lane  <= '0;
            dbeat <= dbeat + 1'b1;
            if (dbeat == len_q) state <= WS_LAST;
          end else begin
            lane <= lane + 1'b1;
          end
        end
        WS_LAST: state <= WS_RESP;
        WS_RESP: if (b_ready) state <= WS_IDLE;
        default: state <= WS_IDLE;
      endcase
    end
  end

  // Observation counters for the properties below.
  logic [LEN_W:0]   taken;
  logic [CNT_W-1:0] emitted;
  always_ff @(posedge clk) begin
    if (rst) begin
      taken   <= '0;
      emitted <= '0;
    end else if (aw_valid && aw_ready) begin
      taken   <= '0;
      emitted <= '0;
    end else begin
      if (w_valid && w_ready) taken <= taken + 1'b1;
      if (mw_valid) emitted <= emitted + 1'b1;
    end
  end

  p_start_full_r3: assert property (@(posedge clk) disable iff (rst)
    mw_start |-> (taken == ({1'b0, len_q} + 1'b1)));

  p_wready_bound_r2: assert property (@(posedge clk) disable iff (rst)
    w_ready |-> (taken <= {1'b0, len_q}));

  p_no_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && ((emitted + CNT_W'(1)) != mw_count)) |=> mw_valid);

  p_b_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mw_valid) |-> (b_valid && b_resp == RESP_OKAY));

  p_b_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !b_ready) |=> b_valid);

endmodule

// File: rtl/sdbuf_rd.sv
// Read direction: request a burst, pack arriving halfwords, replay beats.
module sdbuf_rd
  import sdbuf_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int LEN_W    = 8,
  parameter int DEPTH_HW = 512,
  parameter int CNT_W    = LEN_W + $clog2(BUS_W / 16) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ar_valid,
  output logic             ar_ready,
  input  logic [LEN_W-1:0] ar_len,
  output logic             r_valid,
  input  logic             r_ready,
  output logic [BUS_W-1:0] r_data,
  output logic             r_last,
  output logic             mr_start,
  output logic [CNT_W-1:0] mr_count,
  input  logic             mr_valid,
  input  logic [15:0]      mr_data
);

  localparam int RATIO   = BUS_W / 16;
  localparam int LANE_W  = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int DEPTH_B = DEPTH_HW / RATIO;
  localparam int ADDR_W  = $clog2(DEPTH_B);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(RATIO - 1);

  rd_state_e         state;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  hcnt;
  logic [LANE_W-1:0] lane;
  logic [LEN_W-1:0]  fbeat;
  logic [LEN_W-1:0]  sptr;
  logic [ADDR_W-1:0] raddr;
  logic [BUS_W-1:0]  acc_next;
  logic              fill_take;
  logic              mem_we;

  assign fill_take = (state == RS_FILL) && mr_valid;
  assign mem_we    = fill_take && (lane == LANE_LAST);
  assign ar_ready  = (state == RS_IDLE);
  assign mr_start  = (state == RS_ISSUE);
  assign r_valid   = (state == RS_SEND);
  assign r_last    = (state == RS_SEND) && (sptr == len_q);

  // Packing: newest halfword enters at the top, first one ends at [15:0].
  if (RATIO == 1) begin : g_direct
    assign acc_next = mr_data;
  end else begin : g_pack
    logic [BUS_W-17:0] acc_hi;
    always_ff @(posedge clk) begin
      if (rst)            acc_hi <= '0;
      else if (fill_take) acc_hi <= acc_next[BUS_W-1:16];
    end
    assign acc_next = {mr_data, acc_hi};
  end

  always_comb begin
    if (state == RS_SEND && r_ready) raddr = ADDR_W'(sptr) + ADDR_W'(1);
    else                             raddr = ADDR_W'(sptr);
  end

  sdbuf_ram #(.WIDTH(BUS_W), .DEPTH(DEPTH_B)) u_buf (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ADDR_W'(fbeat)),
    .wdata (acc_next),
    .raddr (raddr),
    .rdata (r_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RS_IDLE;
      len_q    <= '0;
      hcnt     <= '0;
      lane     <= '0;
      fbeat    <= '0;
      sptr     <= '0;
      mr_count <= '0;
    end else begin
      case (state)
        RS_IDLE: if (ar_valid) begin
          len_q    <= ar_len;
          mr_count <= (CNT_W'(ar_len) + CNT_W'(1)) * CNT_W'(RATIO);
          sptr     <= '0;
          state    <= RS_ISSUE;
        end
        RS_ISSUE: begin
          hcnt  <= '0;
          lane  <= '0;
          fbeat <= '0;
          state <= RS_FILL;
        end
        RS_FILL: if (mr_valid) begin
          hcnt <= hcnt + 1'b1;
          if (lane == LANE_LAST) begin
            lane  <= '0;
            fbeat <= fbeat + 1'b1;
          end else begin
            lane <= lane + 1'b1;
          end
          if (hcnt == mr_count - CNT_W'(1)) state <= RS_PREP;
        end
        RS_PREP: state <= RS_SEND;
        RS_SEND: if (r_ready) begin
          sptr <= sptr + 1'b1;
          if (sptr == len_q) state <= RS_IDLE;
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  p_mr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    mr_start |=> !mr_start);

  p_room_r7: assert property (@(posedge clk) disable iff (rst)
    fill_take |-> (32'(hcnt) < DEPTH_HW));

  p_r_after_fill_r8: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> (hcnt == mr_count));

  p_r_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_last)));

endmodule

// File: rtl/sdram_burst_buffer.sv
module sdram_burst_buffer #(
  parameter int BUS_W    = 32,
  parameter int LEN_W    = 8,
  parameter int DEPTH_HW = (2 ** LEN_W) * (BUS_W / 16)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                aw_valid,
  output logic                                aw_ready,
  input  logic [LEN_W-1:0]                    aw_len,
  input  logic                                w_valid,
  output logic                                w_ready,
  input  logic [BUS_W-1:0]                    w_data,
  output logic                                b_valid,
  input  logic                                b_ready,
  output logic [1:0]                          b_resp,
  input  logic                                ar_valid,
  output logic                                ar_ready,
  input  logic [LEN_W-1:0]                    ar_len,
  output logic                                r_valid,
  input  logic                                r_ready,
  output logic [BUS_W-1:0]                    r_data,
  output logic                                r_last,
  output logic                                mw_start,
  output logic                                mw_valid,
  output logic [15:0]                         mw_data,
  output logic [LEN_W+$clog2(BUS_W/16):0]     mw_count,
  output logic                                mr_start,
  output logic [LEN_W+$clog2(BUS_W/16):0]     mr_count,
  input  logic                                mr_valid,
  input  logic [15:0]                         mr_data
);

  localparam int RATIO = BUS_W / 16;
  localparam int CNT_W = LEN_W + $clog2(RATIO) + 1;

  if (BUS_W != 16 && BUS_W != 32 && BUS_W != 64) begin : g_bad_width
    $error("sdram_burst_buffer: BUS_W must be 16, 32 or 64");
  end
  if (DEPTH_HW < (2 ** LEN_W) * RATIO) begin : g_bad_depth
    $error("sdram_burst_buffer: DEPTH_HW cannot hold a maximum-length burst");
  end

  sdbuf_wr #(.BUS_W(BUS_W), .LEN_W(LEN_W), .DEPTH_HW(DEPTH_HW), .CNT_W(CNT_W)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .aw_len   (aw_len),
    .w_valid  (w_valid),
    .w_ready  (w_ready),
    .w_data   (w_data),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .b_resp   (b_resp),
    .mw_start (mw_start),
    .mw_valid (mw_valid),
    .mw_data  (mw_data),
    .mw_count (mw_count)
  );

  sdbuf_rd #(.BUS_W(BUS_W), .LEN_W(LEN_W), .DEPTH_HW(DEPTH_HW), .CNT_W(CNT_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .ar_valid (ar_valid),
    .ar_ready (ar_ready),
    .ar_len   (ar_len),
    .r_valid  (r_valid),
    .r_ready  (r_ready),
    .r_data   (r_data),
    .r_last   (r_last),
    .mr_start (mr_start),
    .mr_count (mr_count),
    .mr_valid (mr_valid),
    .mr_data  (mr_data)
  );

endmodule

// File: tb/tb_sdram_burst_buffer.sv
`timescale 1ns/1ps
module tb_sdram_burst_buffer;

  localparam int BUS_W = 32;
  localparam int LEN_W = 8;
  localparam int RATIO = BUS_W / 16;
  localparam int CNT_W = LEN_W + $clog2(RATIO) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             aw_valid = 0, w_valid = 0, b_ready = 0, ar_valid = 0, r_ready = 0, mr_valid = 0;
  logic [LEN_W-1:0] aw_len = '0, ar_len = '0;
  logic [BUS_W-1:0] w_data = '0;
  logic [15:0]      mr_data = '0;
  logic             aw_ready, w_ready, b_valid, ar_ready, r_valid, r_last;
  logic             mw_start, mw_valid, mr_start;
  logic [1:0]       b_resp;
  logic [BUS_W-1:0] r_data;
  logic [15:0]      mw_data;
  logic [CNT_W-1:0] mw_count, mr_count;

  sdram_burst_buffer #(.BUS_W(BUS_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last),
    .mw_start(mw_start), .mw_valid(mw_valid), .mw_data(mw_data), .mw_count(mw_count),
    .mr_start(mr_start), .mr_count(mr_count), .mr_valid(mr_valid), .mr_data(mr_data)
  );

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [15:0]      wq[$];
  logic [BUS_W-1:0] rq[$];
  bit  wr_busy = 0, wr_all_in = 0, b_due = 0;
  int  wr_left = 0, wr_total = 0, wr_seen = 0;
  bit  rd_busy = 0, rd_issue_due = 0, rd_filling = 0, rd_all_in = 0;
  int  rd_total = 0, rd_got = 0, rd_len = 0, rd_beat = 0, pk_n = 0;
  logic [BUS_W-1:0] pk;
  bit  r_hold = 0;
  logic [BUS_W-1:0] hold_data;
  logic hold_last;

  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      // write direction
      chk(aw_ready == !wr_busy, "R2 aw_ready", aw_ready, !wr_busy);
      chk(w_ready == (wr_busy && !wr_all_in), "R2 w_ready", w_ready, wr_busy && !wr_all_in);
      if (mw_valid) begin
        logic [15:0] e;
        chk(wr_all_in, "R3 halfword before full burst", 0, 1);
        e = (wq.size() > 0) ? wq.pop_front() : 16'hxxxx;
        chk(mw_data === e, "R4 mw_data", mw_data, e);
        chk(mw_start == (wr_seen == 0), "R3 mw_start", mw_start, wr_seen == 0);
        if (wr_seen == 0) chk(int'(mw_count) == wr_total, "R3 mw_count", mw_count, wr_total);
        wr_seen++;
      end else begin
        chk(!mw_start, "R3 mw_start without data", mw_start, 0);
        if (wr_seen > 0 && wr_seen < wr_total) chk(0, "R5 gap in burst", wr_seen, wr_total);
      end
      chk(b_valid == b_due, "R6 b_valid", b_valid, b_due);
      if (b_valid) chk(b_resp == 2'b00, "R6 b_resp", b_resp, 0);
      if (mw_valid && wr_seen == wr_total) b_due = 1;
      if (b_valid && b_ready) begin
        wr_busy = 0; wr_all_in = 0; b_due = 0; wr_seen = 0;
      end
      if (aw_valid && aw_ready) begin
        wr_busy = 1; wr_all_in = 0; wr_seen = 0;
        wr_left = int'(aw_len) + 1;
        wr_total = wr_left * RATIO;
      end
      if (w_valid && w_ready) begin
        for (int k = 0; k < RATIO; k++) wq.push_back(w_data[16*k +: 16]);
        wr_left--;
        if (wr_left == 0) wr_all_in = 1;
      end

      // read direction
      chk(ar_ready == !rd_busy, "R7 ar_ready", ar_ready, !rd_busy);
      chk(mr_start == rd_issue_due, "R7 mr_start", mr_start, rd_issue_due);
      if (mr_start) chk(int'(mr_count) == rd_total, "R7 mr_count", mr_count, rd_total);
      if (mr_valid && rd_filling) begin
        pk[16*pk_n +: 16] = mr_data;
        pk_n++;
        rd_got++;
        if (pk_n == RATIO) begin rq.push_back(pk); pk_n = 0; end
        if (rd_got == rd_total) begin rd_filling = 0; rd_all_in = 1; end
      end
      if (mr_start) begin rd_issue_due = 0; rd_filling = 1; rd_got = 0; pk_n = 0; end
      if (r_valid) begin
        logic [BUS_W-1:0] e;
        chk(rd_all_in, "R8 r_valid before fill complete", 0, 1);
        e = (rq.size() > 0) ? rq[0] : 'x;
        chk(r_data === e, "R8 r_data", r_data, e);
        chk(r_last == (rd_beat == rd_len), "R9 r_last", r_last, rd_beat == rd_len);
        if (r_hold) chk(r_data === hold_data && r_last == hold_last, "R9 hold", r_data, hold_data);
        if (r_ready) begin
          if (rq.size() > 0) void'(rq.pop_front());
          r_hold = 0;
          if (rd_beat == rd_len) begin rd_busy = 0; rd_all_in = 0; end
          rd_beat++;
        end else begin
          r_hold = 1; hold_data = r_data; hold_last = r_last;
        end
      end else begin
        if (r_hold) chk(0, "R9 r_valid dropped", 0, 1);
        r_hold = 0;
        chk(!r_last, "R9 r_last without r_valid", r_last, 0);
      end
      if (ar_valid && ar_ready) begin
        rd_busy = 1; rd_issue_due = 1; rd_all_in = 0; rd_beat = 0;
        rd_len = int'(ar_len);
        rd_total = (rd_len + 1) * RATIO;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_write(input int len, input int stall, input int bdelay);
    @(negedge clk);
    aw_valid = 1; aw_len = LEN_W'(len);
    #1; while (!aw_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    aw_valid = 0;
    for (int b = 0; b <= len; b++) begin
      if (stall > 0 && (b % 3) == 1) repeat (stall) @(negedge clk);
      w_valid = 1; w_data = BUS_W'(rnd());
      #1; while (!w_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      w_valid = 0;
    end
    #1; while (!b_valid) begin @(negedge clk); #1; end
    repeat (bdelay) @(negedge clk);
    if (bdelay == 0) @(negedge clk);
    b_ready = 1;
    @(negedge clk);
    b_ready = 0;
  endtask

  task automatic do_read(input int len, input bit gaps, input bit slow);
    int total = (len + 1) * RATIO;
    int cyc = 0;
    @(negedge clk);
    ar_valid = 1; ar_len = LEN_W'(len);
    #1; while (!ar_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    ar_valid = 0;
    #1; while (!mr_start) begin @(negedge clk); #1; end
    @(negedge clk);
    for (int h = 0; h < total; h++) begin
      mr_valid = 1; mr_data = 16'(rnd());
      @(negedge clk);
      if (gaps && (h % 5) == 2) begin mr_valid = 0; @(negedge clk); end
    end
    mr_valid = 0;
    forever begin
      r_ready = slow ? ((cyc % 3) != 0) : 1'b1;
      cyc++;
      #1;
      if (r_valid && r_ready && r_last) break;
      @(negedge clk);
    end
    @(negedge clk);
    r_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    chk(aw_ready && ar_ready, "R1 ready after reset", {aw_ready, ar_ready}, 2'b11);
    chk(!w_ready && !b_valid && !r_valid && !r_last, "R1 channel valids", {w_ready, b_valid, r_valid, r_last}, 0);
    chk(!mw_valid && !mw_start && !mr_start, "R1 memory side idle", {mw_valid, mw_start, mr_start}, 0);

    // R2: data offered before any address is not taken
    @(negedge clk); w_valid = 1; w_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    w_valid = 0;

    do_write(0, 0, 0);
    do_write(3, 0, 2);
    do_write(15, 2, 0);
    do_write(255, 1, 1);

    // R10: stray memory halfwords with no read in progress
    @(negedge clk); mr_valid = 1; mr_data = 16'hBAD0;
    @(negedge clk); mr_data = 16'hBAD1;
    @(negedge clk); mr_valid = 0;

    do_read(0, 0, 0);
    do_read(1, 1, 1);
    do_read(7, 0, 1);
    do_read(255, 1, 0);

    // R11: both directions at once
    fork
      do_write(9, 1, 1);
      do_read(6, 1, 1);
    join

    repeat (6) @(negedge clk);
    #1;
    chk(wq.size() == 0, "R4 all halfwords written out", wq.size(), 0);
    chk(rq.size() == 0, "R8 all read beats returned", rq.size(), 0);
    chk(!wr_busy && !rd_busy && aw_ready && ar_ready, "R11 both directions idle", {aw_ready, ar_ready}, 2'b11);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule